// File: doc/BRIEF.md
# Sync-Aligned Oversampling Lane Receiver

This block recovers one bit lane of a packet that travels without a clock. Transmitter and receiver run at the same nominal cell rate. The receiver's single clock runs PHASES times faster than a cell, and a free-running phase counter divides each local cell period into PHASES slots. Each slot stands in for one setting of an adjustable delay line.

The line rests low while idle. The first rising edge on the line is the sync cell. The block records the phase slot in which that edge appears and places its sampling point half a cell later. Every later cell is sampled in that same slot, and the alignment is not adjusted again inside the packet. Samples are decoded as NRZI: a change of level since the previous cell is a one, and no change is a zero. The data bits come out one per cell with a one-cycle strobe.

The number of data cells is supplied on an input and is taken at the sync edge. One parity cell follows the data. The block then gives an end-of-packet pulse, and a parity-error flag alongside it. The block is ready for a new sync edge from the cell right after the parity cell, so packets can follow one another with no gap.

Top module: `lane_rx`

## Requirements
- R1: While reset is asserted and after it is released, `bitValid`, `pktEnd` and `parErr` are low until a packet is received.
- R2: A line that stays low produces no output. A packet starts only on a rising edge of the line while the block is idle.
- R3: Each data bit is 1 when the sampled line level differs from the level sampled in the previous cell, and 0 when it is the same. The first data cell is compared with the level sampled in the sync cell. Bits are delivered in the order they are received.
- R4: `blkLen` is taken at the sync edge. Exactly that many data bits are then delivered, each with a one-cycle `bitValid`.
- R5: After the parity cell is sampled, `pktEnd` pulses for exactly one cycle. It is never high in the same cycle as `bitValid`.
- R6: `parErr` is high only in the `pktEnd` cycle. It is set when the line is still high at the parity cell, or when the count of ones is odd. That count covers the sync cell (counted as one), the data cells and the parity cell.
- R7: The sampling slot is the captured sync slot plus PHASES/2, taken modulo PHASES. Data is recovered correctly whatever phase slot the sync edge falls in.
- R8: A sync edge that starts in the cell right after a parity cell begins a new packet, and that packet is received correctly.
- R9: Two `bitValid` strobes are never closer than PHASES cycles apart.
- R10: With `blkLen` = 0, no data bit is delivered. Only the parity cell is checked, and `pktEnd` still pulses.
- R11: A `blkLen` above MAX_CELLS (2000 by default) is treated as MAX_CELLS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, PHASES times the cell rate |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Asynchronous serial lane, idle low |
| blkLen | input | LEN_W | Number of data cells in the next packet |
| bitOut | output | 1 | Decoded data bit, valid with bitValid |
| bitValid | output | 1 | One-cycle strobe per decoded data bit |
| pktEnd | output | 1 | One-cycle pulse after the parity cell |
| parErr | output | 1 | Parity error, meaningful only with pktEnd |

## Verification
The end-of-packet pulse and the parity-error flag are the two functions that share a cycle. The bench provokes this with packets whose parity cell is inverted, which leaves the line high. It judges the result by requiring that each error report arrives on the same cycle as the pulse and never on a cycle without it. A second case involves rearming: the closing of one packet and the sync edge of the next fall half a cell apart. The bench provokes this with two packets sent back to back, and checks that both packets come back complete, with two end pulses and no error.

// File: rtl/lane_rx_pkg.sv
package lane_rx_pkg;

  // Strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic capture;   // sync edge seen: latch the sampling slot
    logic loadRef;   // sample in the sync cell: set the reference level
    logic emitBit;   // sample in a data cell: decode and deliver
    logic closePkt;  // sample in the parity cell: judge the packet
  } laneStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_PAR
  } laneState_t;

endpackage

// File: rtl/lane_rx_dp.sv
module lane_rx_dp
  import lane_rx_pkg::*;
#(
  parameter int PHASES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lineIn,
  input  laneStrobes_t strobes,
  output logic         rise,
  output logic         sampleHit,
  output logic         bitOut,
  output logic         bitValid,
  output logic         pktEnd,
  output logic         parErr
);

  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam int HALF = PHASES / 2;

  logic             syncA, lvl, lvlD;
  logic [PH_W-1:0]  phaseCnt, samplePh;
  logic [PH_W:0]    phaseSum;
  logic             refLvl, runPar;
  logic             diff;

  // two-flop synchronizer plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      lvl   <= 1'b0;
      lvlD  <= 1'b0;
    end else begin
      syncA <= lineIn;
      lvl   <= syncA;
      lvlD  <= lvl;
    end
  end

  assign rise = lvl & ~lvlD;

  // free-running phase slot counter, one wrap per local cell
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phaseCnt <= '0;
    else if (phaseCnt == PH_W'(PHASES - 1))
      phaseCnt <= '0;
    else
      phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    phaseSum = {1'b0, phaseCnt} + (PH_W+1)'(HALF);
    if (phaseSum >= (PH_W+1)'(PHASES))
      phaseSum = phaseSum - (PH_W+1)'(PHASES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      samplePh <= '0;
    else if (strobes.capture)
      samplePh <= phaseSum[PH_W-1:0];
  end

  assign sampleHit = (phaseCnt == samplePh);
  assign diff      = lvl ^ refLvl;

  // NRZI decode, running parity and output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLvl   <= 1'b0;
      runPar   <= 1'b0;
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
      pktEnd   <= 1'b0;
      parErr   <= 1'b0;
    end else begin
      bitValid <= 1'b0;
      pktEnd   <= 1'b0;
      parErr   <= 1'b0;
      if (strobes.loadRef) begin
        refLvl <= lvl;
        runPar <= 1'b1;
      end
      if (strobes.emitBit) begin
        bitOut   <= diff;
        bitValid <= 1'b1;
        refLvl   <= lvl;
        runPar   <= runPar ^ diff;
      end
      if (strobes.closePkt) begin
        pktEnd <= 1'b1;
        parErr <= (runPar ^ diff) | lvl;
        refLvl <= lvl;
      end
    end
  end

endmodule

// File: rtl/lane_rx_ctrl.sv
module lane_rx_ctrl
  import lane_rx_pkg::*;
#(
  parameter int MAX_CELLS = 2000,
  parameter int LEN_W     = $clog2(MAX_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rise,
  input  logic             sampleHit,
  input  logic [LEN_W-1:0] blkLen,
  output laneStrobes_t     strobes
);

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_CELLS);

  laneState_t       state;
  logic [LEN_W-1:0] cellsLeft;

  always_comb begin
    strobes          = '0;
    strobes.capture  = (state == ST_IDLE) && rise;
    strobes.loadRef  = (state == ST_SYNC) && sampleHit;
    strobes.emitBit  = (state == ST_DATA) && sampleHit;
    strobes.closePkt = (state == ST_PAR)  && sampleHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cellsLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rise) begin
          state     <= ST_SYNC;
          cellsLeft <= (blkLen > LEN_CAP) ? LEN_CAP : blkLen;
        end
        ST_SYNC: if (sampleHit)
          state <= (cellsLeft == '0) ? ST_PAR : ST_DATA;
        ST_DATA: if (sampleHit) begin
          if (cellsLeft == LEN_W'(1))
            state <= ST_PAR;
          cellsLeft <= cellsLeft - 1'b1;
        end
        ST_PAR: if (sampleHit)
          state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_rx.sv
module lane_rx
  import lane_rx_pkg::*;
#(
  parameter int PHASES    = 8,
  parameter int MAX_CELLS = 2000,
  parameter int LEN_W     = $clog2(MAX_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic [LEN_W-1:0] blkLen,
  output logic             bitOut,
  output logic             bitValid,
  output logic             pktEnd,
  output logic             parErr
);

  laneStrobes_t strobes;
  logic         rise, sampleHit;

  lane_rx_ctrl #(.MAX_CELLS(MAX_CELLS), .LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rise(rise), .sampleHit(sampleHit),
    .blkLen(blkLen), .strobes(strobes)
  );

  lane_rx_dp #(.PHASES(PHASES)) i_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strobes(strobes),
    .rise(rise), .sampleHit(sampleHit), .bitOut(bitOut),
    .bitValid(bitValid), .pktEnd(pktEnd), .parErr(parErr)
  );

endmodule

// File: rtl/lane_rx_chk.sv
module lane_rx_chk #(
  parameter int PHASES = 8
) (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic pktEnd,
  input logic parErr
);

  localparam int G_W = $clog2(PHASES + 1) + 1;

  // cycles since the last bit strobe, saturating at PHASES
  logic [G_W-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gap <= G_W'(PHASES);
    else if (bitValid)
      gap <= G_W'(1);
    else if (gap < G_W'(PHASES))
      gap <= gap + 1'b1;
  end

  assert_eop_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |=> !pktEnd);

  assert_eop_no_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |-> !bitValid);

  assert_err_with_eop_R6: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> pktEnd);

  assert_bit_spacing_R9: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (gap >= G_W'(PHASES)));

  assert_bit_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

endmodule

bind lane_rx lane_rx_chk #(.PHASES(PHASES)) i_lane_rx_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .pktEnd(pktEnd), .parErr(parErr)
);

// File: tb/test_lane_rx.sv
`timescale 1ns/1ps
module test_lane_rx;

  localparam int K      = 8;
  localparam int MAXC   = 2000;
  localparam int LW     = $clog2(MAXC + 1);
  localparam int NVEC   = 8;
  localparam int WD_CYC = 150000;

  // vector: {len[7:0], data[31:0], corrupt[3:0], lead[3:0]}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd8,  32'h0000_00A5, 4'd0, 4'd0},
    {8'd16, 32'h0000_FF00, 4'd0, 4'd3},
    {8'd32, 32'hDEAD_BEEF, 4'd0, 4'd5},
    {8'd1,  32'h0000_0001, 4'd0, 4'd7},
    {8'd5,  32'h0000_0000, 4'd0, 4'd1},
    {8'd12, 32'h0000_0FFF, 4'd0, 4'd6},
    {8'd20, 32'h0001_2345, 4'd1, 4'd2},
    {8'd0,  32'h0000_0000, 4'd0, 4'd4}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lineIn = 1'b0;
  logic [LW-1:0] blkLen = '0;
  logic          bitOut, bitValid, pktEnd, parErr;

  int checks = 0;
  int errors = 0;

  int         rxCount, eopCount, errCount, cyc, lastValid, minGap, outsSeen;
  logic [127:0] rxBits;

  always #2 clk = ~clk;

  lane_rx #(.PHASES(K), .MAX_CELLS(MAXC)) i_lane_rx (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .blkLen(blkLen),
    .bitOut(bitOut), .bitValid(bitValid), .pktEnd(pktEnd), .parErr(parErr)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bitValid || pktEnd || parErr) outsSeen <= outsSeen + 1;
    if (bitValid) begin
      if (rxCount < 128) rxBits[rxCount] <= bitOut;
      rxCount <= rxCount + 1;
      if (lastValid >= 0 && (cyc - lastValid) < minGap) minGap <= cyc - lastValid;
      lastValid <= cyc;
    end
    if (pktEnd) begin
      eopCount <= eopCount + 1;
      if (parErr) errCount <= errCount + 1;
    end
  end

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    rxCount = 0; eopCount = 0; errCount = 0; outsSeen = 0; rxBits = '0;
  endtask

  task automatic waitCells(input int n);
    repeat (n * K) @(negedge clk);
  endtask

  // sync cell, len data cells from data[i%32], parity cell; tail cells low
  task automatic sendPacket(input int len, input logic [31:0] data,
                            input bit corrupt, input int lead, input int tail);
    logic lv;
    logic p;
    repeat (lead) @(negedge clk);
    lv = 1'b1;
    lineIn = lv;
    waitCells(1);
    for (int i = 0; i < len; i++) begin
      if (data[i % 32]) lv = ~lv;
      lineIn = lv;
      waitCells(1);
    end
    p = lv;
    if (corrupt) p = ~p;
    if (p) lv = ~lv;
    lineIn = lv;
    waitCells(1);
    if (tail > 0) begin
      lineIn = 1'b0;
      waitCells(tail);
    end
  endtask

  function automatic int bitMismatch(input int len, input logic [31:0] data);
    int m = 0;
    for (int i = 0; i < len && i < 128; i++)
      if (rxBits[i] !== data[i % 32]) m++;
    return m;
  endfunction

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc = 0; lastValid = -1; minGap = 1000000;
    clearMon();
    repeat (5) @(negedge clk);
    // R1: outputs low during reset
    checkEq("R1 reset", int'({bitValid, pktEnd, parErr}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1 after reset", int'({bitValid, pktEnd, parErr}), 0);

    // R2: idle low line gives nothing
    clearMon();
    blkLen = LW'(8);
    waitCells(12);
    checkEq("R2 idle line", outsSeen, 0);

    // table walk: R3 R4 R5 R6 R7 R10
    for (int v = 0; v < NVEC; v++) begin
      int len;
      logic [31:0] dat;
      bit cor;
      int lead;
      len  = int'(VEC[v][47:40]);
      dat  = VEC[v][39:8];
      cor  = VEC[v][4];
      lead = int'(VEC[v][3:0]);
      clearMon();
      blkLen = LW'(len);
      sendPacket(len, dat, cor, lead, 3);
      checkEq($sformatf("R4 count vec%0d", v), rxCount, len);
      checkEq($sformatf("R3 R7 bits vec%0d", v), bitMismatch(len, dat), 0);
      checkEq($sformatf("R5 eop vec%0d", v), eopCount, 1);
      checkEq($sformatf("R6 parErr vec%0d", v), errCount, cor ? 1 : 0);
      if (len == 0) checkEq("R10 no bits", rxCount, 0);
    end

    // R8: back-to-back packets, second sync right after parity cell
    clearMon();
    blkLen = LW'(10);
    sendPacket(10, 32'h0000_02B5, 1'b0, 3, 0);
    sendPacket(10, 32'h0000_02B5, 1'b0, 0, 3);
    checkEq("R8 b2b count", rxCount, 20);
    checkEq("R8 b2b eop", eopCount, 2);
    checkEq("R8 b2b err", errCount, 0);
    begin
      int m = 0;
      for (int i = 0; i < 20; i++)
        if (rxBits[i] !== (32'h0000_02B5 >> (i % 10)) % 2) m++;
      checkEq("R8 b2b bits", m, 0);
    end

    // R11: oversized length clamps to MAX_CELLS
    clearMon();
    blkLen = LW'(2047);
    sendPacket(MAXC, 32'h9C3A_5F17, 1'b0, 2, 3);
    checkEq("R11 clamp count", rxCount, MAXC);
    checkEq("R11 clamp eop", eopCount, 1);
    checkEq("R11 clamp err", errCount, 0);

    // R9: strobe spacing across the whole run
    checkEq("R9 min spacing ok", int'(minGap >= K), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule